// File: doc/BRIEF.md
# GPIO Interrupt Channel Router

This block takes a wide vector of GPIO pin inputs and routes up to eight of them onto eight interrupt lines that feed a parent interrupt controller. Each channel has its own pin select, noise filter and trigger setting. It chooses one pin, passes it through a two-flop synchronizer and an optional stability filter, and corrects its polarity. It then presents the result upward either as an active-high level or as a one-cycle pulse on a rising transition. The parent controller therefore only needs to handle level-high and rising-edge sources, whatever the pin actually does.

Software programs four 32-bit configuration words through a small word-addressed write/read port. Pin select values are global indices: software adds a bank's base input number to the pin's position inside that bank. Deciding which pin gets which channel is left to software. Pin muxing and the parent controller sit outside this block.

Top module: `gpio_irq_router`

## Requirements
- R1: Four configuration words at word addresses 0 to 3 read back exactly what was last written, and a write shows in the channel behaviour from the next clock cycle. Word 0 bit n makes channel n edge-triggered, and word 0 bit 16+n makes channel n active-low or falling-edge. Word 1 holds the 8-bit pin selects of channels 0 to 3, and word 2 holds those of channels 4 to 7, with channel n at bits [8*(n mod 4)+7 : 8*(n mod 4)]. Word 3 holds the 4-bit filter setting of channel n at bits [4n+3:4n].
- R2: After reset, every configuration word reads zero. With all pins low, every interrupt output is low.
- R3: A channel's select value is a global index into the pin vector. Select value s routes input pin s, including pins beyond the first bank (for example pin 130).
- R4: A select value at or above the implemented pin count reads as a constant 0 on that channel, whatever any pin does.
- R5: In level mode with the polarity bit clear, the output follows the pin. A pin change first sampled at clock edge k shows at the output after edge k-1+2+max(F,1), where F is the channel's filter setting. For a pin driven between edges k-1 and k, that is 2+max(F,1) edges later.
- R6: In level mode with the polarity bit set, the output is the inverse of the pin, with the same latency as R5.
- R7: In edge mode with the polarity bit clear, a low-to-high pin transition gives exactly one output cycle high, with the R5 latency. A high-to-low transition gives no pulse.
- R8: In edge mode with the polarity bit set, a high-to-low pin transition gives exactly one output cycle high. A low-to-high transition gives none.
- R9: With a nonzero filter setting F, the filtered value changes only after the synchronized pin has differed from it for F consecutive cycles. A pulse of fewer than F cycles never reaches the output.
- R10: A filter setting of 0 bypasses the filter and has the same latency as a setting of 1.
- R11: After a write that changes a channel's select, edge bit or polarity bit, that channel's edge pulse output stays low for F+5 cycles, so re-targeting or re-polarizing cannot raise a spurious pulse. Later transitions pulse normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data of the addressed word (combinational) |
| pin_in | input | NUM_PINS | Global GPIO pin input vector |
| irq_out | output | 8 | Active-high level or rising-pulse lines to the parent controller |

## Verification
The bench goes after the filter threshold. A pulse one cycle shorter than the setting must vanish, and a pulse of full length must pass at exactly 2+F cycles. A filter with an off-by-one count would either let the glitch through or shift the edge. It checks that selects beyond the implemented pins stay at zero while every real pin is driven high; a mux that wraps or truncates the index would show a one there. It re-targets an edge channel onto a pin that is already high, and flips a channel's polarity while its pin is low. A design that does not clear the edge history on such changes would raise a pulse a few cycles after the write. The falling-edge and active-low cases check that the polarity fix happens before edge detection, so the parent sees a rising pulse or a high level.

// File: rtl/gir_pkg.sv
package gir_pkg;
  localparam int NCH          = 8;
  localparam int SEL_W        = 8;
  localparam int FILT_W       = 4;
  localparam int WORD_W       = 32;
  localparam int NWORDS       = 4;
  localparam int ADDR_W       = $clog2(NWORDS);
  localparam int PIN_SPACE    = 1 << SEL_W;
  localparam int SEL_PER_WORD = WORD_W / SEL_W;
  localparam int LOW_BASE     = 16;
  localparam int W_TRIG       = 0;
  localparam int W_SEL0       = 1;
  localparam int W_FILT       = 3;
  localparam int SETTLE_EXTRA = 4;
  localparam int SETTLE_W     = FILT_W + 1;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic              edge_mode;
    logic              act_low;
    logic [FILT_W-1:0] filt;
  } chan_cfg_t;

  // True when one more mismatching cycle reaches the programmed threshold.
  function automatic logic filt_reached(input logic [FILT_W-1:0] cnt,
                                        input logic [FILT_W-1:0] thr);
    return ({1'b0, cnt} + 1'b1) >= {1'b0, thr};
  endfunction

  // Number of quiet cycles after a channel re-target or re-polarize.
  function automatic logic [SETTLE_W-1:0] settle_len(input logic [FILT_W-1:0] thr);
    return {1'b0, thr} + SETTLE_W'(SETTLE_EXTRA);
  endfunction
endpackage

// File: rtl/gir_regs.sv
module gir_regs
  import gir_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [ADDR_W-1:0]      cfg_addr,
  input  logic [WORD_W-1:0]      cfg_wdata,
  output logic [WORD_W-1:0]      cfg_rdata,
  output chan_cfg_t [NCH-1:0]    cfg_o
);
  logic [WORD_W-1:0] word_q [NWORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) word_q[i] <= '0;
    end else if (cfg_we) begin
      word_q[cfg_addr] <= cfg_wdata;
    end
  end

  assign cfg_rdata = word_q[cfg_addr];

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      cfg_o[n].sel       = word_q[W_SEL0 + n / SEL_PER_WORD][(n % SEL_PER_WORD) * SEL_W +: SEL_W];
      cfg_o[n].edge_mode = word_q[W_TRIG][n];
      cfg_o[n].act_low   = word_q[W_TRIG][LOW_BASE + n];
      cfg_o[n].filt      = word_q[W_FILT][n * FILT_W +: FILT_W];
    end
  end

  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (word_q[$past(cfg_addr)] == $past(cfg_wdata)));
endmodule

// File: rtl/gir_pin_select.sv
module gir_pin_select
  import gir_pkg::*;
#(
  parameter int NUM_PINS = 146
) (
  input  logic [NUM_PINS-1:0] pins,
  input  logic [SEL_W-1:0]    sel,
  output logic                pin_o
);
  logic [PIN_SPACE-1:0] space;

  generate
    if (NUM_PINS < PIN_SPACE) begin : g_pad
      assign space = {{(PIN_SPACE-NUM_PINS){1'b0}}, pins};
    end else begin : g_full
      assign space = pins[PIN_SPACE-1:0];
    end
  endgenerate

  assign pin_o = space[sel];
endmodule

// File: rtl/gir_filter.sv
module gir_filter
  import gir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic [FILT_W-1:0] thr,
  output logic              dout
);
  logic [FILT_W-1:0] cnt_q;
  logic              q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= 1'b0;
      cnt_q <= '0;
    end else if (thr == '0) begin
      q     <= din;
      cnt_q <= '0;
    end else if (din == q) begin
      cnt_q <= '0;
    end else if (filt_reached(cnt_q, thr)) begin
      q     <= din;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign dout = q;

  // R9: a fresh input change can never move the output on the next edge when F >= 2
  a_r9_filter_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (thr >= FILT_W'(2) && !$stable(din)) |=> $stable(q));
endmodule

// File: rtl/gir_channel.sv
module gir_channel
  import gir_pkg::*;
#(
  parameter int NUM_PINS = 146
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins,
  input  chan_cfg_t           cfg,
  output logic                irq_o
);
  logic                  pin_raw;
  logic                  sync1_q, sync2_q;
  logic                  filt_val;
  logic                  pol_val;
  logic                  hist_q;
  logic [SEL_W+1:0]      key_now, key_q;
  logic                  cfg_changed;
  logic [SETTLE_W-1:0]   settle_q;
  logic                  quiet;
  logic                  edge_hit;

  gir_pin_select #(.NUM_PINS(NUM_PINS)) u_sel (
    .pins (pins),
    .sel  (cfg.sel),
    .pin_o(pin_raw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= pin_raw;
      sync2_q <= sync1_q;
    end
  end

  gir_filter u_filt (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (sync2_q),
    .thr  (cfg.filt),
    .dout (filt_val)
  );

  assign pol_val     = filt_val ^ cfg.act_low;
  assign key_now     = {cfg.sel, cfg.edge_mode, cfg.act_low};
  assign cfg_changed = (key_now != key_q);
  assign quiet       = cfg_changed || (settle_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q    <= '0;
      settle_q <= '0;
      hist_q   <= 1'b0;
    end else begin
      key_q  <= key_now;
      hist_q <= pol_val;
      if (cfg_changed)          settle_q <= settle_len(cfg.filt);
      else if (settle_q != '0)  settle_q <= settle_q - 1'b1;
    end
  end

  assign edge_hit = pol_val && !hist_q && !quiet;
  assign irq_o    = cfg.edge_mode ? edge_hit : pol_val;

  // R7: an edge-mode pulse lasts one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.edge_mode && irq_o) |=> (!irq_o || !cfg.edge_mode));

  // R11: re-targeting an edge channel raises no pulse in that cycle
  a_r11_no_pulse_on_retarget: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.edge_mode && !$stable(cfg.sel)) |-> !irq_o);

  // R4: an unimplemented select feeds only zeros into the synchronizer
  a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cfg.sel) >= NUM_PINS) |=> !sync1_q);
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gir_pkg::*;
#(
  parameter int NUM_PINS = 146
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [WORD_W-1:0]   cfg_wdata,
  output logic [WORD_W-1:0]   cfg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NCH-1:0]      irq_out
);
  chan_cfg_t [NCH-1:0] chan_cfg;

  gir_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .cfg_o    (chan_cfg)
  );

  generate
    for (genvar n = 0; n < NCH; n++) begin : g_chan
      gir_channel #(.NUM_PINS(NUM_PINS)) u_chan (
        .clk  (clk),
        .rst_n(rst_n),
        .pins (pin_in),
        .cfg  (chan_cfg[n]),
        .irq_o(irq_out[n])
      );
    end
  endgenerate
endmodule

// File: tb/gpio_irq_router_bench.sv
module gpio_irq_router_bench;
  localparam int NP = 146;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [NP-1:0] pins;
  logic [7:0]  irq;

  always #5 clk = ~clk;

  gpio_irq_router #(.NUM_PINS(NP)) u_gpio_irq_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pin_in(pins), .irq_out(irq)
  );

  typedef struct {
    int         at;
    logic [7:0] mask;
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  logic [31:0] trig;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Driver side: queue an expected output value, kept in cycle order.
  task automatic expect_at(input int off, input logic [7:0] mask, input logic [7:0] val, input string tag);
    exp_t e;
    int idx;
    e.at = cyc + off; e.mask = mask; e.val = val; e.tag = tag;
    idx = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].at > e.at) begin idx = i; break; end
    end
    q.insert(idx, e);
  endtask

  task automatic expect_win(input int from, input int to, input logic [7:0] mask, input logic [7:0] val, input string tag);
    for (int k = from; k <= to; k++) expect_at(k, mask, val, tag);
  endtask

  // Monitor side: compare due items away from the active edge.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      cur = q.pop_front();
      if (cur.at < cyc) check(1'b0, {cur.tag, " missed"}, 32'(irq), 32'(cur.val & cur.mask));
      else check((irq & cur.mask) == (cur.val & cur.mask), cur.tag, 32'(irq & cur.mask), 32'(cur.val & cur.mask));
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      check(1'b0, "watchdog", 32'(cyc), 32'd20000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [31:0] exp, input string tag);
    cfg_addr = a;
    #1;
    check(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; pins = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R2: reset state
    for (int a = 0; a < 4; a++) rd_check(2'(a), 32'h0, "R2 reset word");
    check(irq == 8'h00, "R2 reset irq", 32'(irq), 32'h0);

    // R1: read-back of arbitrary patterns
    wr(2'd0, 32'hA5A5_5A5A); wr(2'd1, 32'h1234_5678);
    wr(2'd2, 32'hDEAD_BEEF); wr(2'd3, 32'h0F0F_F0F0);
    rd_check(2'd0, 32'hA5A5_5A5A, "R1 word0");
    rd_check(2'd1, 32'h1234_5678, "R1 word1");
    rd_check(2'd2, 32'hDEAD_BEEF, "R1 word2");
    rd_check(2'd3, 32'h0F0F_F0F0, "R1 word3");

    // Working configuration
    trig = (32'd1 << 17) | (32'd1 << 3) | (32'd1 << 4) | (32'd1 << 20);
    wr(2'd1, {8'd20, 8'd200, 8'd130, 8'd5});
    wr(2'd2, {8'd41, 8'd41, 8'd40, 8'd21});
    wr(2'd3, 32'h0140_0000);
    wr(2'd0, trig);
    rd_check(2'd0, trig, "R1 word0 config");
    idle(25);
    check(irq == 8'h02, "R6 active-low idle level", 32'(irq), 32'h02);

    // R5: level, active high, F=0
    pins[5] = 1'b1;
    expect_at(2, 8'h01, 8'h00, "R5 rise not early");
    expect_at(3, 8'h01, 8'h01, "R5 rise");
    idle(6);
    pins[5] = 1'b0;
    expect_at(2, 8'h01, 8'h01, "R5 fall not early");
    expect_at(3, 8'h01, 8'h00, "R5 fall");
    idle(6);

    // R6 / R3: active-low level on global pin 130
    pins[130] = 1'b1;
    expect_at(2, 8'h02, 8'h02, "R6 not early");
    expect_at(3, 8'h02, 8'h00, "R3 R6 pin130 inverted");
    idle(6);
    pins[130] = 1'b0;
    expect_at(3, 8'h02, 8'h02, "R6 back high");
    idle(6);

    // R4: select 200 beyond implemented pins stays zero
    expect_win(1, 10, 8'h04, 8'h00, "R4 unmapped select");
    pins = '1;
    idle(10);
    pins = '0;
    idle(20);

    // R7: rising edge pulse
    pins[20] = 1'b1;
    expect_at(2, 8'h08, 8'h00, "R7 not early");
    expect_at(3, 8'h08, 8'h08, "R7 pulse");
    expect_win(4, 9, 8'h08, 8'h00, "R7 single cycle");
    idle(10);
    pins[20] = 1'b0;
    expect_win(1, 8, 8'h08, 8'h00, "R7 no pulse on fall");
    idle(10);

    // R8: falling edge pulse
    pins[21] = 1'b1;
    expect_win(1, 8, 8'h10, 8'h00, "R8 no pulse on rise");
    idle(10);
    pins[21] = 1'b0;
    expect_at(2, 8'h10, 8'h00, "R8 not early");
    expect_at(3, 8'h10, 8'h10, "R8 pulse");
    expect_win(4, 7, 8'h10, 8'h00, "R8 single cycle");
    idle(8);

    // R9: filter F=4, glitch of 3 cycles rejected, 4+ passes
    expect_win(1, 14, 8'h20, 8'h00, "R9 glitch rejected");
    pins[40] = 1'b1;
    idle(3);
    pins[40] = 1'b0;
    idle(14);
    pins[40] = 1'b1;
    expect_at(5, 8'h20, 8'h00, "R9 rise not early");
    expect_at(6, 8'h20, 8'h20, "R9 rise after F");
    expect_at(10, 8'h20, 8'h20, "R9 hold");
    idle(12);
    pins[40] = 1'b0;
    expect_at(5, 8'h20, 8'h20, "R9 fall not early");
    expect_at(6, 8'h20, 8'h00, "R9 fall after F");
    idle(10);

    // R10: F=1 and F=0 share latency
    pins[41] = 1'b1;
    expect_at(2, 8'hC0, 8'h00, "R10 not early");
    expect_at(3, 8'hC0, 8'hC0, "R10 same latency");
    idle(6);
    pins[41] = 1'b0;
    expect_at(3, 8'hC0, 8'h00, "R10 fall");
    idle(6);

    // R11: re-target ch0 (edge rising) onto a pin already high
    trig = trig | 32'd1;
    wr(2'd0, trig);
    idle(20);
    pins[10] = 1'b1;
    idle(5);
    expect_win(1, 16, 8'h01, 8'h00, "R11 no pulse on retarget");
    wr(2'd1, {8'd20, 8'd200, 8'd130, 8'd10});
    idle(16);
    pins[10] = 1'b0;
    idle(6);
    pins[10] = 1'b1;
    expect_at(3, 8'h01, 8'h01, "R11 later edge pulses");
    expect_at(4, 8'h01, 8'h00, "R11 later edge single");
    idle(6);
    pins[10] = 1'b0;
    idle(8);
    // R11: polarity flip with pin low must not pulse
    expect_win(1, 12, 8'h01, 8'h00, "R11 no pulse on polarity flip");
    trig = trig | (32'd1 << 16);
    wr(2'd0, trig);
    idle(14);

    idle(5);
    check(q.size() == 0, "scoreboard drained", 32'(q.size()), 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule